// File: doc/BRIEF.md
# Banked General-Register File with Console Window

This block holds the general registers of a 16-bit minicomputer-style CPU. It has sixteen physical 16-bit words: two banks of six working registers (numbers 0 to 5), one stack pointer for each of the three privilege modes, and one shared program counter. The CPU reaches them by 3-bit register number. The number is resolved against a bank-select bit and a 2-bit privilege mode, so one number can name different physical words.

A separate console port reaches all sixteen words directly through a 16-word window at the very top of the physical address space. Each word sits one address above the previous one, even though the words are 16 bits wide. The CPU's own memory bus must never reach that storage. Any CPU bus request into the window is left unanswered by the block, which signals a bus timeout error after a fixed count of cycles.

Top module: `gprf_top`

## Requirements
- R1: After reset every physical register reads 0, `con_rvalid`, `con_err` and `bus_err` are low, and `con_ready` is high from the first clock edge after `rst_n` rises.
- R2: On the CPU port, register numbers 0 to 5 address bank 0 when `cpu_bank` is 0 and bank 1 when it is 1. `cpu_rdata` follows `cpu_rnum` without a clock, and a write with `cpu_we` is visible after the next edge.
- R3: CPU register number 6 selects a stack pointer by `cpu_mode`: 2'b00 selects the kernel SP, 2'b01 the supervisor SP, and 2'b11 or 2'b10 the user SP.
- R4: CPU register number 7 selects the single program counter for every bank and mode setting.
- R5: A console address hits the window when every bit above bit 5 is 1 and bits 5:4 are 0. Bits 3:0 pick the word: 0-5 bank 0 R0-R5, 6 kernel SP, 7 PC, 8-13 bank 1 R0-R5, 14 supervisor SP, 15 user SP. With 22 physical bits the window is octal 17777700-17777717.
- R6: A console read is accepted when `con_valid` and `con_ready` are high at an edge. One cycle later `con_rvalid` pulses for one cycle with `con_rdata` equal to the word's value before that edge.
- R7: An accepted console write inside the window updates the word at the accepting edge. Its response pulse has `con_err` = 0 and `con_rdata` = 0.
- R8: An accepted console access outside the window returns `con_err` = 1 and `con_rdata` = 0 and changes no register.
- R9: When the CPU and the console write the same physical word at the same edge, the console data is stored. Writes to different words both take effect.
- R10: A CPU bus request held at a 16-bit address from octal 177700 to 177717 gives a one-cycle `bus_err` pulse TMO_CYCLES edges after the request is first sampled, and the pulse repeats at that period while the request is held. Requests outside that range never raise `bus_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_mode | input | 2 | Current privilege mode |
| cpu_bank | input | 1 | Working-register bank select |
| cpu_rnum | input | 3 | Register number for the read port |
| cpu_rdata | output | 16 | Read data (combinational) |
| cpu_we | input | 1 | CPU write enable |
| cpu_wnum | input | 3 | Register number for the write port |
| cpu_wdata | input | 16 | CPU write data |
| bus_req | input | 1 | CPU memory bus request |
| bus_addr | input | 16 | CPU bus virtual address |
| bus_err | output | 1 | Bus timeout error pulse |
| con_valid | input | 1 | Console request valid |
| con_ready | output | 1 | Console port ready |
| con_we | input | 1 | Console write (1) or read (0) |
| con_addr | input | 22 | Console physical address |
| con_wdata | input | 16 | Console write data |
| con_rvalid | output | 1 | Console response pulse |
| con_rdata | output | 16 | Console read data |
| con_err | output | 1 | Console address outside window |

## Verification
Every word is first loaded with a distinct value through the console. All eight register numbers are then read under each bank and mode setting, so a swapped bank, a wrong stack pointer, or a program counter that depends on the bank shows as a wrong value. CPU writes under each setting are checked back through the console at the expected offset, which also tests the address-to-word order in the other direction. Addresses just outside the window, both above the 16th word and with one upper bit cleared, separate the window decode from a looser decode. Colliding writes to the same word and to different words show whether the console wins only on a collision. The bus timeout is timed edge by edge and tried just below and just above the window.

// File: rtl/gprf_pkg.sv
package gprf_pkg;
  localparam int NREG  = 16;
  localparam int IDX_W = $clog2(NREG);

  typedef enum logic [1:0] {
    MODE_KERN = 2'b00,
    MODE_SUPV = 2'b01,
    MODE_RSVD = 2'b10,
    MODE_USER = 2'b11
  } priv_mode_e;

  localparam logic [IDX_W-1:0] IDX_KSP = 4'd6;
  localparam logic [IDX_W-1:0] IDX_PC  = 4'd7;
  localparam logic [IDX_W-1:0] IDX_SSP = 4'd14;
  localparam logic [IDX_W-1:0] IDX_USP = 4'd15;

  // Resolve a CPU register number to a physical word index.
  function automatic logic [IDX_W-1:0] cpu_to_phys(input logic [2:0] num,
                                                   input logic bank,
                                                   input logic [1:0] mode);
    logic [IDX_W-1:0] idx;
    if (num == 3'd7) begin
      idx = IDX_PC;
    end else if (num == 3'd6) begin
      case (priv_mode_e'(mode))
        MODE_KERN: idx = IDX_KSP;
        MODE_SUPV: idx = IDX_SSP;
        default:   idx = IDX_USP;
      endcase
    end else begin
      idx = {bank, num};
    end
    return idx;
  endfunction
endpackage

// File: rtl/gprf_store.sv
module gprf_store #(
  parameter int W  = 16,
  parameter int N  = 16,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lo_we,
  input  logic [IW-1:0] lo_idx,
  input  logic [W-1:0]  lo_d,
  input  logic          hi_we,
  input  logic [IW-1:0] hi_idx,
  input  logic [W-1:0]  hi_d,
  output logic [N*W-1:0] flat
);
  for (genvar i = 0; i < N; i++) begin : g_word
    logic [W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                            q <= '0;
      else if (hi_we && hi_idx == IW'(i))    q <= hi_d;
      else if (lo_we && lo_idx == IW'(i))    q <= lo_d;
    end
    assign flat[i*W +: W] = q;
  end
endmodule

// File: rtl/gprf_con_port.sv
module gprf_con_port #(
  parameter int W    = 16,
  parameter int N    = 16,
  parameter int PA_W = 22,
  localparam int IW  = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            con_valid,
  input  logic            con_we,
  input  logic [PA_W-1:0] con_addr,
  input  logic [W-1:0]    con_wdata,
  input  logic [N*W-1:0]  flat,
  output logic            con_ready,
  output logic            con_rvalid,
  output logic [W-1:0]    con_rdata,
  output logic            con_err,
  output logic            acc,
  output logic            hit,
  output logic            wr_en,
  output logic [IW-1:0]   wr_idx
);
  function automatic logic in_window(input logic [PA_W-1:0] a);
    return (&a[PA_W-1:6]) && (a[5:4] == 2'b00);
  endfunction

  logic          ready_q;
  logic [W-1:0]  rd_val;

  assign con_ready = ready_q;
  assign acc       = con_valid && ready_q;
  assign hit       = in_window(con_addr);
  assign wr_idx    = con_addr[IW-1:0];
  assign wr_en     = acc && con_we && hit;
  assign rd_val    = flat[wr_idx*W +: W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_q    <= 1'b0;
      con_rvalid <= 1'b0;
      con_err    <= 1'b0;
      con_rdata  <= '0;
    end else begin
      ready_q    <= 1'b1;
      con_rvalid <= acc;
      con_err    <= acc && !hit;
      con_rdata  <= (acc && !con_we && hit) ? rd_val : '0;
    end
  end
endmodule

// File: rtl/gprf_bus_tmo.sv
module gprf_bus_tmo #(
  parameter int VA_W       = 16,
  parameter int TMO_CYCLES = 16,
  localparam int CW        = $clog2(TMO_CYCLES + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_req,
  input  logic [VA_W-1:0] bus_addr,
  output logic            bus_hit,
  output logic            bus_err
);
  function automatic logic va_in_window(input logic [VA_W-1:0] a);
    return (&a[VA_W-1:6]) && (a[5:4] == 2'b00);
  endfunction

  logic [CW-1:0] cnt;
  logic          expire;

  assign bus_hit = bus_req && va_in_window(bus_addr);
  assign expire  = bus_hit && (cnt == CW'(TMO_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      bus_err <= 1'b0;
    end else begin
      bus_err <= expire;
      if (!bus_hit || expire) cnt <= '0;
      else                    cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/gprf_top.sv
module gprf_top #(
  parameter int W          = 16,
  parameter int PA_W       = 22,
  parameter int VA_W       = 16,
  parameter int TMO_CYCLES = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      cpu_mode,
  input  logic            cpu_bank,
  input  logic [2:0]      cpu_rnum,
  output logic [W-1:0]    cpu_rdata,
  input  logic            cpu_we,
  input  logic [2:0]      cpu_wnum,
  input  logic [W-1:0]    cpu_wdata,
  input  logic            bus_req,
  input  logic [VA_W-1:0] bus_addr,
  output logic            bus_err,
  input  logic            con_valid,
  output logic            con_ready,
  input  logic            con_we,
  input  logic [PA_W-1:0] con_addr,
  input  logic [W-1:0]    con_wdata,
  output logic            con_rvalid,
  output logic [W-1:0]    con_rdata,
  output logic            con_err
);
  import gprf_pkg::*;

  logic [NREG*W-1:0] reg_flat;
  logic [IDX_W-1:0]  cpu_rd_idx;
  logic [IDX_W-1:0]  cpu_wr_idx;
  logic              con_acc;
  logic              con_hit;
  logic              con_wr_en;
  logic [IDX_W-1:0]  con_wr_idx;
  logic              bus_hit;

  assign cpu_rd_idx = cpu_to_phys(cpu_rnum, cpu_bank, cpu_mode);
  assign cpu_wr_idx = cpu_to_phys(cpu_wnum, cpu_bank, cpu_mode);
  assign cpu_rdata  = reg_flat[cpu_rd_idx*W +: W];

  gprf_store #(.W(W), .N(NREG)) u_store (
    .clk(clk), .rst_n(rst_n),
    .lo_we(cpu_we), .lo_idx(cpu_wr_idx), .lo_d(cpu_wdata),
    .hi_we(con_wr_en), .hi_idx(con_wr_idx), .hi_d(con_wdata),
    .flat(reg_flat)
  );

  gprf_con_port #(.W(W), .N(NREG), .PA_W(PA_W)) u_con (
    .clk(clk), .rst_n(rst_n),
    .con_valid(con_valid), .con_we(con_we), .con_addr(con_addr),
    .con_wdata(con_wdata), .flat(reg_flat),
    .con_ready(con_ready), .con_rvalid(con_rvalid), .con_rdata(con_rdata),
    .con_err(con_err), .acc(con_acc), .hit(con_hit),
    .wr_en(con_wr_en), .wr_idx(con_wr_idx)
  );

  gprf_bus_tmo #(.VA_W(VA_W), .TMO_CYCLES(TMO_CYCLES)) u_tmo (
    .clk(clk), .rst_n(rst_n),
    .bus_req(bus_req), .bus_addr(bus_addr),
    .bus_hit(bus_hit), .bus_err(bus_err)
  );
endmodule

// File: rtl/gprf_chk.sv
module gprf_chk #(
  parameter int W = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_we,
  input logic [3:0]    cpu_wr_idx,
  input logic          con_acc,
  input logic          con_hit,
  input logic          con_we,
  input logic          con_wr_en,
  input logic [3:0]    con_wr_idx,
  input logic [W-1:0]  con_wdata,
  input logic          con_rvalid,
  input logic          con_err,
  input logic [W-1:0]  con_rdata,
  input logic          bus_hit,
  input logic          bus_err,
  input logic [16*W-1:0] reg_flat
);
  logic         coll;
  logic [3:0]   coll_idx_q;
  logic [W-1:0] coll_d_q;

  assign coll = con_wr_en && cpu_we && (con_wr_idx == cpu_wr_idx);

  always_ff @(posedge clk) begin
    coll_idx_q <= con_wr_idx;
    coll_d_q   <= con_wdata;
  end

  AST_RESP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    con_rvalid |-> $past(con_acc)); // R6
  AST_ERR_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (con_acc && !con_hit) |=> (con_err && con_rdata == '0)); // R8
  AST_OUTSIDE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (con_acc && !con_hit && !cpu_we) |=> $stable(reg_flat)); // R8
  AST_WRITE_RESP_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (con_acc && con_hit && con_we) |=> (con_rvalid && !con_err && con_rdata == '0)); // R7
  AST_CONSOLE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    coll |=> (reg_flat[coll_idx_q*W +: W] == coll_d_q)); // R9
  AST_BUSERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |=> !bus_err); // R10
  AST_BUSERR_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(bus_hit)); // R10
endmodule

bind gprf_top gprf_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_wr_idx(cpu_wr_idx),
  .con_acc(con_acc), .con_hit(con_hit), .con_we(con_we),
  .con_wr_en(con_wr_en), .con_wr_idx(con_wr_idx), .con_wdata(con_wdata),
  .con_rvalid(con_rvalid), .con_err(con_err), .con_rdata(con_rdata),
  .bus_hit(bus_hit), .bus_err(bus_err), .reg_flat(reg_flat)
);

// File: tb/sim_gprf_top.sv
module sim_gprf_top;
  localparam int W = 16, PA_W = 22, VA_W = 16, TMO = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] cpu_mode = '0;
  logic cpu_bank = 1'b0, cpu_we = 1'b0;
  logic [2:0] cpu_rnum = '0, cpu_wnum = '0;
  logic [W-1:0] cpu_wdata = '0, cpu_rdata;
  logic bus_req = 1'b0, bus_err;
  logic [VA_W-1:0] bus_addr = '0;
  logic con_valid = 1'b0, con_we = 1'b0, con_ready, con_rvalid, con_err;
  logic [PA_W-1:0] con_addr = '0;
  logic [W-1:0] con_wdata = '0, con_rdata;

  int n_cmp = 0, n_bad = 0;
  logic [W-1:0] model [16];

  always #4 clk = ~clk;

  gprf_top #(.W(W), .PA_W(PA_W), .VA_W(VA_W), .TMO_CYCLES(TMO)) u0 (.*);

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [PA_W-1:0] win(input int off);
    return {{(PA_W-6){1'b1}}, 6'(off)};
  endfunction

  // Independent word-offset model of CPU naming.
  function automatic int phys_of(input int num, input int bank, input int mode);
    if (num == 7) return 7;
    if (num == 6) return (mode == 0) ? 6 : (mode == 1) ? 14 : 15;
    return bank * 8 + num;
  endfunction

  task automatic con_op(input logic we, input logic [PA_W-1:0] a, input logic [W-1:0] d,
                        output logic [W-1:0] rd, output logic er, output logic rv);
    @(negedge clk);
    con_valid = 1'b1; con_we = we; con_addr = a; con_wdata = d;
    @(negedge clk);
    con_valid = 1'b0;
    rd = con_rdata; er = con_err; rv = con_rvalid;
  endtask

  task automatic t_reset();
    logic [W-1:0] rd; logic er, rv;
    chk("R1 ready", {15'd0, con_ready}, 16'd1);
    chk("R1 rvalid", {15'd0, con_rvalid}, 16'd0);
    chk("R1 bus_err", {15'd0, bus_err}, 16'd0);
    for (int i = 0; i < 16; i++) begin
      con_op(1'b0, win(i), '0, rd, er, rv);
      chk("R1 reg zero", rd, 16'd0);
    end
    chk("R1 err", {15'd0, er}, 16'd0);
  endtask

  task automatic t_con_fill();
    logic [W-1:0] rd; logic er, rv;
    for (int i = 0; i < 16; i++) begin
      model[i] = 16'hA000 + 16'(i * 16'h0111);
      con_op(1'b1, win(i), model[i], rd, er, rv);
      chk("R7 write rvalid", {15'd0, rv}, 16'd1);
      chk("R7 write err", {15'd0, er}, 16'd0);
      chk("R7 write rdata", rd, 16'd0);
    end
    for (int i = 15; i >= 0; i--) begin
      con_op(1'b0, win(i), '0, rd, er, rv);
      chk("R5 R6 console readback", rd, model[i]);
      chk("R6 rvalid", {15'd0, rv}, 16'd1);
      @(negedge clk);
      chk("R6 rvalid one cycle", {15'd0, con_rvalid}, 16'd0);
    end
  endtask

  task automatic t_cpu_read_map();
    for (int m = 0; m < 4; m++)
      for (int b = 0; b < 2; b++)
        for (int n = 0; n < 8; n++) begin
          @(negedge clk);
          cpu_mode = 2'(m); cpu_bank = 1'(b); cpu_rnum = 3'(n);
          #1;
          if (n < 6)       chk("R2 bank read", cpu_rdata, model[phys_of(n, b, m)]);
          else if (n == 6) chk("R3 stack pointer read", cpu_rdata, model[phys_of(n, b, m)]);
          else             chk("R4 pc read", cpu_rdata, model[7]);
        end
  endtask

  task automatic t_cpu_write_map();
    logic [W-1:0] rd; logic er, rv;
    for (int m = 0; m < 4; m++)
      for (int b = 0; b < 2; b++)
        for (int n = 0; n < 8; n++) begin
          int p;
          p = phys_of(n, b, m);
          @(negedge clk);
          cpu_mode = 2'(m); cpu_bank = 1'(b); cpu_we = 1'b1; cpu_wnum = 3'(n);
          cpu_wdata = 16'h5000 + 16'(m * 256 + b * 16 + n);
          model[p] = cpu_wdata;
          @(negedge clk);
          cpu_we = 1'b0;
          con_op(1'b0, win(p), '0, rd, er, rv);
          if (n < 6)       chk("R2 cpu write", rd, model[p]);
          else if (n == 6) chk("R3 cpu sp write", rd, model[p]);
          else             chk("R4 cpu pc write", rd, model[p]);
        end
  endtask

  task automatic t_out_window();
    logic [W-1:0] rd; logic er, rv;
    logic [PA_W-1:0] bad [3];
    bad[0] = win(16); bad[1] = win(5) & ~(22'd1 << 21); bad[2] = win(3) & ~(22'd1 << 6);
    for (int k = 0; k < 3; k++) begin
      con_op(1'b1, bad[k], 16'hDEAD, rd, er, rv);
      chk("R8 err flag", {15'd0, er}, 16'd1);
      chk("R8 rdata zero", rd, 16'd0);
      con_op(1'b0, bad[k], '0, rd, er, rv);
      chk("R8 read err", {15'd0, er}, 16'd1);
    end
    for (int i = 0; i < 16; i++) begin
      con_op(1'b0, win(i), '0, rd, er, rv);
      chk("R8 unchanged", rd, model[i]);
    end
  endtask

  task automatic t_conflict();
    logic [W-1:0] rd; logic er, rv;
    @(negedge clk);
    cpu_mode = 2'b01; cpu_bank = 1'b0; cpu_we = 1'b1; cpu_wnum = 3'd6; cpu_wdata = 16'h1111;
    con_valid = 1'b1; con_we = 1'b1; con_addr = win(14); con_wdata = 16'h2222;
    @(negedge clk);
    cpu_we = 1'b0; con_valid = 1'b0; model[14] = 16'h2222;
    con_op(1'b0, win(14), '0, rd, er, rv);
    chk("R9 console wins", rd, 16'h2222);
    @(negedge clk);
    cpu_bank = 1'b1; cpu_we = 1'b1; cpu_wnum = 3'd2; cpu_wdata = 16'h3333;
    con_valid = 1'b1; con_we = 1'b1; con_addr = win(2); con_wdata = 16'h4444;
    @(negedge clk);
    cpu_we = 1'b0; con_valid = 1'b0; model[10] = 16'h3333; model[2] = 16'h4444;
    con_op(1'b0, win(10), '0, rd, er, rv);
    chk("R9 cpu side kept", rd, 16'h3333);
    con_op(1'b0, win(2), '0, rd, er, rv);
    chk("R9 console side kept", rd, 16'h4444);
  endtask

  task automatic bus_try(input logic [VA_W-1:0] a, input int exp_n);
    int got;
    got = 0;
    @(negedge clk);
    bus_req = 1'b1; bus_addr = a;
    for (int n = 1; n <= 3 * TMO; n++) begin
      @(negedge clk);
      if (bus_err && got == 0) got = n;
      if (got != 0 && n == got + 1) chk("R10 pulse width", {15'd0, bus_err}, 16'd0);
      if (got != 0 && n == got + TMO) chk("R10 repeat", {15'd0, bus_err}, 16'd1);
    end
    bus_req = 1'b0;
    chk("R10 timeout edge", 16'(got), 16'(exp_n));
  endtask

  task automatic t_bus();
    bus_try(16'hFFC0, TMO);
    bus_try(16'hFFCF, TMO);
    bus_try(16'hFFC7, TMO);
    bus_try(16'hFFD0, 0);
    bus_try(16'hFFBF, 0);
  endtask

  bit done = 1'b0;
  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_con_fill();
    t_cpu_read_map();
    t_cpu_write_map();
    t_out_window();
    t_conflict();
    t_bus();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule